// File: doc/BRIEF.md
# Punctured Convolutional Encoder with Two-Bit Symbol Output

This block turns a serial bit stream into a punctured convolutional code. Each accepted input bit enters a shift history. Two generator masks, both K bits wide, select which history taps are XORed together, so every input yields two encoded bits. A pair of puncture masks, each N bits long, decides which of these two bits survive at each position of a repeating pattern.

The surviving bits are not sent one at a time. They are gathered over a block of 2N accepted inputs, which always holds 2M kept bits. M is the number of ones in the two masks together. The block is then released as M two-bit symbols on consecutive enabled cycles. Releasing a block takes fewer cycles than gathering the next one, so the block never needs to hold off its source, and its ready flag stays high.

A first-data strobe, taken together with a new-data strobe, moves the pattern so that the current input becomes position 0. Upstream framing logic uses this to re-align the block.

Top module: `pcenc_pair_top`

## Requirements
- R1: While rst_n is low, or after an edge where both ce and sclr are high, dout_valid is 0, dout is 00, the encoder history is all zero and the puncture position is 0.
- R2: rfd is 1 in every cycle.
- R3: For an accepted input (ce=1, nd=1, sclr=0), the first code bit is the XOR over j of G0[j] & x(j), and the second code bit uses G1 in the same way. Here x(0) is the current input and x(j) is the input accepted j acceptances earlier; inputs before a clear count as 0.
- R4: Accepted input number p of a block (p = 0 .. 2N-1) uses pattern index i = p mod N. It keeps the first code bit when P0[i]=1 and the second when P1[i]=1. Bit 0 of a mask is the first position.
- R5: Kept bits go out in encoding order, with the first code bit ahead of the second within one input. Each symbol carries the earlier bit on dout[0] and the later bit on dout[1]. dout is 00 whenever dout_valid is 0.
- R6: After the edge that accepts the last input of a block, dout_valid is high for exactly M consecutive ce-enabled cycles. With one input per cycle at the default rate 3/4, the output runs 4 cycles valid and then 2 cycles idle.
- R7: An edge with nd=0 changes neither the history nor the puncture position nor the gathered bits. Output release still proceeds.
- R8: An edge with fd=1 and nd=1 makes the current input position 0 and discards the bits gathered for the unfinished block. A block already being released continues. fd with nd=0 has no effect.
- R9: With ce=0, all state holds and din, nd, fd and sclr are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; low freezes the block |
| sclr | input | 1 | Synchronous clear, qualified by ce |
| din | input | 1 | Data bit to encode |
| nd | input | 1 | New-data strobe; tie high when every cycle carries a bit |
| fd | input | 1 | First-data strobe; restarts the pattern at the current input |
| dout | output | 2 | Output symbol; earlier kept bit on bit 0 |
| dout_valid | output | 1 | Marks a valid symbol on dout |
| rfd | output | 1 | Ready for data; constant 1 |

## Verification
The hardest situation to reach is a first-data strobe that lands while the previous block is still being released and the next block is partly gathered. The release must continue unharmed, the partial bits must vanish, and the new block must complete exactly 2N inputs after the strobe. The bench reaches this by sweeping the strobe over every position of a block under continuous input, with sparse new-data and clock-enable gaps mixed in. It compares every cycle against an arithmetic model of the history, the masks and the release counter.

// File: rtl/pcenc_pkg.sv
package pcenc_pkg;
  // number of set bits in a mask, used to size the release block
  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned s;
    s = 0;
    for (int i = 0; i < 32; i++) s += int'(v[i]);
    return s;
  endfunction
endpackage

// File: rtl/pcenc_conv_core.sv
module pcenc_conv_core #(
  parameter int unsigned K = 7,
  parameter logic [K-1:0] G0 = 7'b1111001,
  parameter logic [K-1:0] G1 = 7'b1011011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  input  logic din,
  output logic code0,
  output logic code1
);
  logic [K-2:0] hist_q, hist_d;
  logic [K-1:0] window;

  // bit 0 = current input, bit j = input accepted j steps earlier
  assign window = {hist_q, din};
  assign code0  = ^(window & G0);
  assign code1  = ^(window & G1);

  always_comb begin
    hist_d = hist_q;
    if (clear)     hist_d = '0;
    else if (step) hist_d = {hist_q[K-3:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/pcenc_punct_pack.sv
module pcenc_punct_pack #(
  parameter int unsigned N  = 3,
  parameter logic [N-1:0] P0 = 3'b101,
  parameter logic [N-1:0] P1 = 3'b011,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  input  logic          restart,
  input  logic          code0,
  input  logic          code1,
  output logic          blk_done,
  output logic [CW-1:0] blk_bits
);
  localparam int unsigned BLK = 2 * N;
  localparam int unsigned PW  = $clog2(BLK);
  localparam logic [PW-1:0] LAST = PW'(BLK - 1);
  localparam logic [PW-1:0] NPOS = PW'(N);

  logic [PW-1:0] pos_q, pos_d, pos_eff, idx;
  logic [CW-1:0] col_q, col_d, col_base, col_new;
  logic          keep0, keep1;

  always_comb begin
    pos_eff  = (step && restart) ? '0 : pos_q;
    col_base = (step && restart) ? '0 : col_q;
    idx      = (pos_eff >= NPOS) ? pos_eff - NPOS : pos_eff;
    keep0    = P0[idx];
    keep1    = P1[idx];
    case ({keep0, keep1})
      2'b11:   col_new = {col_base[CW-3:0], code0, code1};
      2'b10:   col_new = {col_base[CW-2:0], code0};
      2'b01:   col_new = {col_base[CW-2:0], code1};
      default: col_new = col_base;
    endcase
    blk_done = step && (pos_eff == LAST);
    blk_bits = col_new;
    pos_d    = pos_q;
    col_d    = col_q;
    if (clear) begin
      pos_d = '0;
      col_d = '0;
    end else if (step) begin
      pos_d = blk_done ? '0 : pos_eff + 1'b1;
      col_d = blk_done ? '0 : col_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      col_q <= '0;
    end else begin
      pos_q <= pos_d;
      col_q <= col_d;
    end
  end
endmodule

// File: rtl/pcenc_pair_emit.sv
module pcenc_pair_emit #(
  parameter int unsigned M = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           clear,
  input  logic           load,
  input  logic [2*M-1:0] bits,
  output logic [1:0]     dout,
  output logic           dout_valid
);
  localparam int unsigned SW = 2 * M;
  localparam int unsigned CNW = $clog2(M + 1);

  logic [SW-1:0]  sr_q, sr_d;
  logic [CNW-1:0] cnt_q, cnt_d;

  // oldest kept bit sits at the MSB of the block
  assign dout       = {sr_q[SW-2], sr_q[SW-1]};
  assign dout_valid = (cnt_q != '0);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clear) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (load) begin
      sr_d  = bits;
      cnt_d = CNW'(M);
    end else if (adv && cnt_q != '0) begin
      sr_d  = {sr_q[SW-3:0], 2'b00};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pcenc_pair_top.sv
module pcenc_pair_top #(
  parameter int unsigned K = 7,
  parameter logic [K-1:0] G0 = 7'b1111001,
  parameter logic [K-1:0] G1 = 7'b1011011,
  parameter int unsigned N = 3,
  parameter logic [N-1:0] P0 = 3'b101,
  parameter logic [N-1:0] P1 = 3'b011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  logic       sclr,
  input  logic       din,
  input  logic       nd,
  input  logic       fd,
  output logic [1:0] dout,
  output logic       dout_valid,
  output logic       rfd
);
  import pcenc_pkg::*;
  localparam int unsigned M  = ones32(32'(P0)) + ones32(32'(P1));
  localparam int unsigned CW = 2 * M;

  logic step, clear, code0, code1, blk_done;
  logic [CW-1:0] blk_bits;

  assign clear = ce && sclr;
  assign step  = ce && nd && !sclr;
  assign rfd   = 1'b1;

  pcenc_conv_core #(.K(K), .G0(G0), .G1(G1)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .clear(clear),
    .din(din), .code0(code0), .code1(code1)
  );

  pcenc_punct_pack #(.N(N), .P0(P0), .P1(P1), .CW(CW)) u_pack (
    .clk(clk), .rst_n(rst_n), .step(step), .clear(clear), .restart(fd),
    .code0(code0), .code1(code1), .blk_done(blk_done), .blk_bits(blk_bits)
  );

  pcenc_pair_emit #(.M(M)) u_emit (
    .clk(clk), .rst_n(rst_n), .adv(ce), .clear(clear), .load(blk_done),
    .bits(blk_bits), .dout(dout), .dout_valid(dout_valid)
  );
endmodule

// File: rtl/pcenc_pair_chk.sv
module pcenc_pair_chk #(
  parameter int unsigned M = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce,
  input logic       sclr,
  input logic       nd,
  input logic [1:0] dout,
  input logic       dout_valid
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= 0;
    else if (!dout_valid)      run_q <= 0;
    else if (ce && !sclr)      run_q <= run_q + 1;
  end

  assert_clear_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && sclr) |=> (!dout_valid && dout == 2'b00));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> dout == 2'b00);

  assert_burst_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= M);

  assert_start_after_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_valid) |-> $past(ce && nd && !sclr));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(dout) && $stable(dout_valid)));
endmodule

bind pcenc_pair_top pcenc_pair_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .nd(nd),
  .dout(dout), .dout_valid(dout_valid)
);

// File: tb/tb_pcenc_pair_top.sv
module tb_pcenc_pair_top;
  localparam int K = 7;
  localparam logic [6:0] G0 = 7'b1111001;
  localparam logic [6:0] G1 = 7'b1011011;
  localparam int N = 3;
  localparam logic [2:0] P0 = 3'b101;
  localparam logic [2:0] P1 = 3'b011;
  localparam int M = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sclr = 1'b0, din = 1'b0, nd = 1'b0, fd = 1'b0;
  logic [1:0] dout;
  logic dout_valid, rfd;

  always #2 clk = ~clk;

  pcenc_pair_top #(.K(K), .G0(G0), .G1(G1), .N(N), .P0(P0), .P1(P1)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .din(din), .nd(nd),
    .fd(fd), .dout(dout), .dout_valid(dout_valid), .rfd(rfd)
  );

  int checks = 0, fails = 0;
  logic [15:0] lfsr = 16'hACE1;
  // model state
  logic [7:0] hist = '0;
  int pos = 0, nb = 0, oidx = 0, ocnt = 0;
  bit blk [0:15];
  bit outb[0:15];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    hist = '0; pos = 0; nb = 0; oidx = 0; ocnt = 0;
    for (int i = 0; i < 16; i++) begin blk[i] = 0; outb[i] = 0; end
  endtask

  task automatic model_edge(input bit c, input bit s, input bit n, input bit f, input bit d);
    bit load, c0, c1;
    logic [6:0] w;
    int idx;
    load = 0;
    if (!c) return;                          // R9: frozen
    if (s) begin model_clear(); return; end   // R1
    if (n) begin                             // R7: only accepted inputs move
      if (f) begin pos = 0; nb = 0; end      // R8
      w = {hist[5:0], d};                    // R3: bit 0 = current input
      c0 = ^(w & G0);
      c1 = ^(w & G1);
      idx = pos % N;                         // R4
      if (P0[idx]) begin blk[nb] = c0; nb++; end
      if (P1[idx]) begin blk[nb] = c1; nb++; end
      hist = {hist[6:0], d};
      if (pos == 2*N-1) begin
        for (int i = 0; i < 2*M; i++) outb[i] = blk[i];
        oidx = 0; ocnt = M; pos = 0; nb = 0; load = 1;
      end else pos++;
    end
    if (!load && ocnt > 0) begin oidx += 2; ocnt--; end
  endtask

  task automatic check_out(input string tag);
    logic [1:0] e;
    e = (ocnt > 0) ? {outb[oidx+1], outb[oidx]} : 2'b00;
    chk(dout_valid == (ocnt > 0), "R6 valid timing", int'(dout_valid), int'(ocnt > 0));
    chk(dout == e, tag, int'(dout), int'(e));
    chk(rfd == 1'b1, "R2 rfd", int'(rfd), 1);
  endtask

  task automatic step(input bit c, input bit s, input bit n, input bit f, input bit d,
                      input string tag);
    ce = c; sclr = s; nd = n; fd = f; din = d;
    @(posedge clk);
    model_edge(c, s, n, f, d);
    @(negedge clk);
    check_out(tag);
  endtask

  function automatic bit nextbit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dout_valid == 1'b0, "R1 reset valid", int'(dout_valid), 0);
    chk(dout == 2'b00, "R1 reset dout", int'(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 R5 R6: continuous input, 4 valid / 2 idle cadence
    for (int i = 0; i < 60; i++) step(1, 0, 1, 0, nextbit(), "R3 R5 code");
    // R4: all-ones data exercising every mask position
    for (int i = 0; i < 24; i++) step(1, 0, 1, 0, 1'b1, "R4 puncture");
    // R7: sparse new-data
    for (int i = 0; i < 80; i++) step(1, 0, (i % 3) != 1, 0, nextbit(), "R7 nd gaps");
    // R9: clock-enable gaps; sclr and fd toggled while ce is low
    for (int i = 0; i < 80; i++) step((i % 4) != 2, (i % 4) == 2, 1, (i % 4) == 2, nextbit(),
                                      "R9 ce gaps");
    // R8: sweep first-data over every block position, including during release
    for (int p = 0; p < 2*N; p++) begin
      for (int i = 0; i < 2*N + p; i++) step(1, 0, 1, 0, nextbit(), "R8 lead");
      step(1, 0, 1, 1, nextbit(), "R8 strobe");
      for (int i = 0; i < 3*N; i++) step(1, 0, 1, 0, nextbit(), "R8 after");
      step(1, 0, 0, 1, nextbit(), "R8 fd without nd");
      for (int i = 0; i < 2*N; i++) step(1, 0, 1, 0, nextbit(), "R8 tail");
    end
    // R1: synchronous clear mid-block and mid-release
    for (int i = 0; i < 7; i++) step(1, 0, 1, 0, nextbit(), "R1 pre");
    step(1, 1, 1, 0, nextbit(), "R1 sclr");
    chk(dout_valid == 1'b0, "R1 after sclr", int'(dout_valid), 0);
    for (int i = 0; i < 30; i++) step(1, 0, 1, 0, nextbit(), "R1 post");
    // drain
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 1'b0, "R6 drain");
    chk(dout_valid == 1'b0, "R6 drained", int'(dout_valid), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule